// File: doc/BRIEF.md
# Video Memory Bus Arbiter

This block lets a single-port video SRAM serve two masters: the scan-out address counter that feeds the display, and an external pixel-writing controller. The scanner holds the bus at all times except inside a permitted access window. That window is a shortened copy of the blanking interval, short enough that any write begun inside it finishes before the picture resumes. The controller asks for the bus by pulling an active-low select. The arbiter grants it only on the first cycle of a window. While the controller owns the bus, its address is steered onto the SRAM pins and the SRAM read enable is dropped.

A write runs as a fixed sequence. First the address and data are latched and driven for a setup phase with write enable still inactive. Next comes the strobe phase with write enable low. Then a hold phase keeps address and data steady after the strobe ends. When the controller lets go, or its window closes, a release phase keeps the last address on the pins with the data drivers off before the scanner's address returns. Each phase length is a parameter.

On the display side, SRAM read data goes into a pixel register that loads only while the picture is visible and is cleared during blanking.

Top module: `vram_bus_arbiter`

## Requirements
- R1: During reset and on the first cycle after it, the scanner owns the bus: `memAddr` equals `scanAddr`, `memOeN`=0, `memWeN`=1, `memDataOe`=0 and `pixelOut`=0. An asserted reset aborts a write in progress and forces `memWeN` high at once.
- R2: While the scanner owns the bus, `memAddr` follows `scanAddr` in the same cycle and `memOeN` is 0.
- R3: A grant happens only at the clock edge where `permitBlank` is 1 and was 0 at the previous edge, and `ctlSelN` is 0. A select made before a window opens waits for the next window start. A select made while a window is already open is not granted until the next window start.
- R4: While the controller owns the bus and no write is running, `memAddr` follows `ctlAddr`, `memOeN`=1, `memWeN`=1 and `memDataOe`=0.
- R5: Suppose the bus is owned, `ctlWrReq`=1 and `permitBlank`=1 at an edge. The arbiter then latches `ctlAddr` and `ctlData` and enters a setup phase of SETUP_CYC cycles with `memWeN`=1. A strobe phase of STROBE_CYC cycles follows with `memWeN`=0, then a hold phase of HOLD_CYC cycles with `memWeN`=1. Through all three phases `memAddr` and `memWrData` show the latched values and `memDataOe`=1. Defaults are 1, 2 and 1.
- R6: A write request seen while `permitBlank`=0 starts no write. Ownership is released instead.
- R7: If `ctlSelN` is 1 or `permitBlank` is 0 at an edge while the bus is owned and idle, a release phase of RELEASE_CYC cycles follows. During it `memAddr` holds the last controller address, `memDataOe`=0, `memWeN`=1 and `memOeN`=1. The scanner takes over after it.
- R8: A write already started runs all of its phases even if `permitBlank` falls during it. It then goes to the release phase rather than back to ownership.
- R9: `pixelOut` is loaded from `memRdData` at each edge where `visBlank`=0, and is loaded with 0 at each edge where `visBlank`=1 (1 means blanking).
- R10: `memWeN` is never 0 unless the address has been latched and driven for at least SETUP_CYC cycles, and never 0 while `visBlank`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rstN | input | 1 | Asynchronous reset, active low |
| scanAddr | input | ADDR_W | Scan-out counter address |
| visBlank | input | 1 | 1 during the display blanking interval |
| permitBlank | input | 1 | 1 during the shortened access window |
| ctlSelN | input | 1 | Controller bus request, active low |
| ctlAddr | input | ADDR_W | Controller address |
| ctlData | input | DATA_W | Controller write data |
| ctlWrReq | input | 1 | Controller write request |
| memRdData | input | DATA_W | SRAM read data |
| memAddr | output | ADDR_W | SRAM address |
| memWrData | output | DATA_W | SRAM write data |
| memDataOe | output | 1 | Enable for the write-data drivers |
| memWeN | output | 1 | SRAM write enable, active low |
| memOeN | output | 1 | SRAM output enable, active low |
| pixelOut | output | DATA_W | Display pixel register |

## Verification
A sequencer stuck in the wrong phase shows at the SRAM pins within one cycle. For example, the scanner address reappears while `memOeN` is still high, or `memWeN` falls while `memDataOe` is low or before the setup phase has run. A phase counter that miscounts makes the write-enable pulse one cycle too long or short, or shifts the hold cycle, so the bench compares the strobe's start and end edges cycle by cycle. A wrong window-edge detector grants a select made mid-window, which shows as `memAddr` switching to the controller address on a cycle when it should still follow `scanAddr`.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  typedef enum logic [2:0] {
    ST_SCAN,
    ST_OWN,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RELEASE
  } arb_state_e;

  typedef struct packed {
    logic scanOwn;      // scanner address on the pins, SRAM read enabled
    logic ctlLive;      // controller address passed straight through
    logic addrLatchEn;  // capture controller address
    logic dataLatchEn;  // capture controller data (write start)
    logic dataDrive;    // write-data drivers on
    logic weAct;        // write strobe active
  } arb_strobe_t;

endpackage

// File: rtl/vram_arb_ctrl.sv
module vram_arb_ctrl
  import vram_arb_pkg::*;
#(
  parameter int SETUP_CYC   = 1,
  parameter int STROBE_CYC  = 2,
  parameter int HOLD_CYC    = 1,
  parameter int RELEASE_CYC = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        permitBlank,
  input  logic        ctlSelN,
  input  logic        ctlWrReq,
  output arb_strobe_t strobe
);

  localparam int MAX_AB  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CD  = (HOLD_CYC > RELEASE_CYC) ? HOLD_CYC : RELEASE_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  localparam logic [CNT_W-1:0] SETUP_LD   = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LD  = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD    = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RELEASE_LD = CNT_W'(RELEASE_CYC - 1);

  arb_state_e       state, stateNext;
  logic [CNT_W-1:0] phaseCnt, phaseCntNext;
  logic             permitPrev;
  logic             windowOpen;
  logic             phaseDone;
  logic             keepOwn;
  logic             startWrite;

  assign windowOpen = permitBlank && !permitPrev;
  assign phaseDone  = (phaseCnt == '0);
  assign keepOwn    = !ctlSelN && permitBlank;
  assign startWrite = (state == ST_OWN) && keepOwn && ctlWrReq;

  always_comb begin
    stateNext    = state;
    phaseCntNext = phaseCnt;
    unique case (state)
      ST_SCAN: begin
        if (windowOpen && !ctlSelN) stateNext = ST_OWN;
      end
      ST_OWN: begin
        if (!keepOwn) begin
          stateNext    = ST_RELEASE;
          phaseCntNext = RELEASE_LD;
        end else if (ctlWrReq) begin
          stateNext    = ST_SETUP;
          phaseCntNext = SETUP_LD;
        end
      end
      ST_SETUP: begin
        if (phaseDone) begin
          stateNext    = ST_STROBE;
          phaseCntNext = STROBE_LD;
        end else begin
          phaseCntNext = phaseCnt - 1'b1;
        end
      end
      ST_STROBE: begin
        if (phaseDone) begin
          stateNext    = ST_HOLD;
          phaseCntNext = HOLD_LD;
        end else begin
          phaseCntNext = phaseCnt - 1'b1;
        end
      end
      ST_HOLD: begin
        if (phaseDone) begin
          if (keepOwn) begin
            stateNext = ST_OWN;
          end else begin
            stateNext    = ST_RELEASE;
            phaseCntNext = RELEASE_LD;
          end
        end else begin
          phaseCntNext = phaseCnt - 1'b1;
        end
      end
      ST_RELEASE: begin
        if (phaseDone) stateNext = ST_SCAN;
        else           phaseCntNext = phaseCnt - 1'b1;
      end
      default: stateNext = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_SCAN;
      phaseCnt   <= '0;
      permitPrev <= 1'b1;  // no grant in the middle of a window open at reset
    end else begin
      state      <= stateNext;
      phaseCnt   <= phaseCntNext;
      permitPrev <= permitBlank;
    end
  end

  always_comb begin
    strobe.scanOwn     = (state == ST_SCAN);
    strobe.ctlLive     = (state == ST_OWN);
    strobe.addrLatchEn = (state == ST_OWN);
    strobe.dataLatchEn = startWrite;
    strobe.dataDrive   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    strobe.weAct       = (state == ST_STROBE);
  end

  // p_grant_window_r3: ownership begins only on a window-opening edge with select low
  p_grant_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.ctlLive) && $past(strobe.scanOwn)
      |-> $past(permitBlank) && !$past(permitBlank, 2) && !$past(ctlSelN));

  // p_strobe_after_setup_r5: the strobe is always preceded by the setup phase
  p_strobe_after_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.weAct) |-> $past(state) == ST_SETUP);

  // p_hold_after_strobe_r5: the strobe always ends into the hold phase
  p_hold_after_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.weAct) |-> state == ST_HOLD);

endmodule

// File: rtl/vram_arb_datapath.sv
module vram_arb_datapath
  import vram_arb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  arb_strobe_t       strobe,
  input  logic              visBlank,
  input  logic [ADDR_W-1:0] scanAddr,
  input  logic [ADDR_W-1:0] ctlAddr,
  input  logic [DATA_W-1:0] ctlData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memDataOe,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] pixelOut
);

  localparam int AGE_W = $clog2(SETUP_CYC + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] pixelReg;
  logic [AGE_W-1:0]  latchAge;
  logic              useLatch;

  assign useLatch = !strobe.scanOwn && !strobe.ctlLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.addrLatchEn) addrReg <= ctlAddr;
      if (strobe.dataLatchEn) dataReg <= ctlData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pixelReg <= '0;
    else if (visBlank) pixelReg <= '0;
    else               pixelReg <= memRdData;
  end

  // cycles the latched controller address has been on the pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    latchAge <= '0;
    else if (!useLatch)           latchAge <= '0;
    else if (latchAge != AGE_MAX) latchAge <= latchAge + 1'b1;
  end

  always_comb begin
    if (strobe.scanOwn)      memAddr = scanAddr;
    else if (strobe.ctlLive) memAddr = ctlAddr;
    else                     memAddr = addrReg;
  end

  assign memWrData = dataReg;
  assign memDataOe = strobe.dataDrive;
  assign memWeN    = !strobe.weAct;
  assign memOeN    = !strobe.scanOwn;
  assign pixelOut  = pixelReg;

  // p_we_after_setup_r10: the address has been held for the setup count before write enable
  p_we_after_setup_r10: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (int'(latchAge) >= SETUP_CYC) && memDataOe && memOeN);

  // p_no_visible_write_r10: no write strobe while the picture is visible
  p_no_visible_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> visBlank);

  // p_hold_stable_r5: address and data stay put on the cycle after the strobe ends
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDataOe && (memAddr == $past(memAddr)) && $stable(memWrData));

  // p_scan_read_r2: the SRAM read enable tracks scanner ownership, never during a write
  p_scan_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> memWeN && !memDataOe);

endmodule

// File: rtl/vram_bus_arbiter.sv
module vram_bus_arbiter
  import vram_arb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 1,
  parameter int STROBE_CYC  = 2,
  parameter int HOLD_CYC    = 1,
  parameter int RELEASE_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] scanAddr,
  input  logic              visBlank,
  input  logic              permitBlank,
  input  logic              ctlSelN,
  input  logic [ADDR_W-1:0] ctlAddr,
  input  logic [DATA_W-1:0] ctlData,
  input  logic              ctlWrReq,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memDataOe,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] pixelOut
);

  arb_strobe_t strobe;

  vram_arb_ctrl #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .RELEASE_CYC(RELEASE_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .permitBlank(permitBlank),
    .ctlSelN    (ctlSelN),
    .ctlWrReq   (ctlWrReq),
    .strobe     (strobe)
  );

  vram_arb_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SETUP_CYC(SETUP_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .visBlank (visBlank),
    .scanAddr (scanAddr),
    .ctlAddr  (ctlAddr),
    .ctlData  (ctlData),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .memDataOe(memDataOe),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .pixelOut (pixelOut)
  );

endmodule

// File: tb/vram_bus_arbiter_bench.sv
module vram_bus_arbiter_bench;

  localparam int AW = 16;
  localparam int DW = 8;

  typedef struct packed {
    logic          sel;
    logic          wr;
    logic          pb;
    logic          vb;
    logic [AW-1:0] ca;
    logic [DW-1:0] cd;
    logic [AW-1:0] sa;
    logic [DW-1:0] rd;
    logic [AW-1:0] exAddr;
    logic          exWeN;
    logic          exOeN;
    logic          exDoe;
    logic [DW-1:0] exWd;
    logic [DW-1:0] exPix;
    logic [3:0]    req;
  } vec_t;

  localparam int NVEC = 23;
  // fields: sel wr pb vb ca cd sa rd | addr weN oeN doe wd pix | req
  localparam vec_t VEC [NVEC] = '{
    '{1,0,0,0,16'h1000,8'hA5,16'h0010,8'h33, 16'h0010,1,0,0,8'h00,8'h33, 4'd9}, // R9 R2 visible load
    '{0,0,0,0,16'h1000,8'hA5,16'h0011,8'h44, 16'h0011,1,0,0,8'h00,8'h44, 4'd3}, // R3 select pending
    '{0,0,0,1,16'h1000,8'hA5,16'h0012,8'h55, 16'h0012,1,0,0,8'h00,8'h00, 4'd9}, // R9 blank clears
    '{0,0,1,1,16'h1000,8'hA5,16'h0013,8'h55, 16'h1000,1,1,0,8'h00,8'h00, 4'd3}, // R3 grant at window start
    '{0,1,1,1,16'h1234,8'hA5,16'h0014,8'h55, 16'h1234,1,1,1,8'hA5,8'h00, 4'd5}, // R5 setup
    '{0,0,1,1,16'h5555,8'h11,16'h0015,8'h55, 16'h1234,0,1,1,8'hA5,8'h00, 4'd5}, // R5 strobe 1
    '{0,0,1,1,16'h5555,8'h11,16'h0016,8'h55, 16'h1234,0,1,1,8'hA5,8'h00, 4'd5}, // R5 strobe 2
    '{0,0,1,1,16'h5555,8'h11,16'h0017,8'h55, 16'h1234,1,1,1,8'hA5,8'h00, 4'd5}, // R5 hold
    '{0,0,1,1,16'h5555,8'h11,16'h0018,8'h55, 16'h5555,1,1,0,8'h00,8'h00, 4'd4}, // R4 back to owned
    '{1,0,1,1,16'h5555,8'h11,16'h0019,8'h55, 16'h5555,1,1,0,8'h00,8'h00, 4'd7}, // R7 release
    '{1,0,1,1,16'h5555,8'h11,16'h0020,8'h55, 16'h0020,1,0,0,8'h00,8'h00, 4'd7}, // R7 scanner back
    '{0,0,1,1,16'h5555,8'h11,16'h0021,8'h55, 16'h0021,1,0,0,8'h00,8'h00, 4'd3}, // R3 mid-window select
    '{0,0,0,1,16'h5555,8'h11,16'h0022,8'h55, 16'h0022,1,0,0,8'h00,8'h00, 4'd3}, // R3 still pending
    '{0,0,1,1,16'h0777,8'h11,16'h0023,8'h55, 16'h0777,1,1,0,8'h00,8'h00, 4'd4}, // R4 next window grant
    '{0,1,0,1,16'h0777,8'h11,16'h0024,8'h55, 16'h0777,1,1,0,8'h00,8'h00, 4'd6}, // R6 no write, release
    '{0,0,0,1,16'h0777,8'h11,16'h0030,8'h55, 16'h0030,1,0,0,8'h00,8'h00, 4'd6}, // R6 scanner back
    '{0,0,1,1,16'h0ABC,8'h11,16'h0031,8'h55, 16'h0ABC,1,1,0,8'h00,8'h00, 4'd3}, // R3 grant
    '{0,1,1,1,16'h0ABC,8'h5A,16'h0032,8'h55, 16'h0ABC,1,1,1,8'h5A,8'h00, 4'd5}, // R5 setup
    '{0,0,0,1,16'h0ABC,8'h5A,16'h0033,8'h55, 16'h0ABC,0,1,1,8'h5A,8'h00, 4'd8}, // R8 strobe, window closed
    '{0,0,0,1,16'h0ABC,8'h5A,16'h0034,8'h55, 16'h0ABC,0,1,1,8'h5A,8'h00, 4'd8}, // R8 strobe 2
    '{0,0,0,1,16'h0ABC,8'h5A,16'h0035,8'h55, 16'h0ABC,1,1,1,8'h5A,8'h00, 4'd8}, // R8 hold
    '{0,0,0,1,16'h0ABC,8'h5A,16'h0036,8'h55, 16'h0ABC,1,1,0,8'h00,8'h00, 4'd8}, // R8 release not own
    '{0,0,0,0,16'h0ABC,8'h5A,16'h0040,8'h66, 16'h0040,1,0,0,8'h00,8'h66, 4'd9}  // R9 scanner, visible
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] scanAddr = '0;
  logic          visBlank = 1'b0;
  logic          permitBlank = 1'b0;
  logic          ctlSelN = 1'b1;
  logic [AW-1:0] ctlAddr = '0;
  logic [DW-1:0] ctlData = '0;
  logic          ctlWrReq = 1'b0;
  logic [DW-1:0] memRdData = '0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWrData;
  logic          memDataOe;
  logic          memWeN;
  logic          memOeN;
  logic [DW-1:0] pixelOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vram_bus_arbiter u_vram_bus_arbiter (
    .clk        (clk),
    .rstN       (rstN),
    .scanAddr   (scanAddr),
    .visBlank   (visBlank),
    .permitBlank(permitBlank),
    .ctlSelN    (ctlSelN),
    .ctlAddr    (ctlAddr),
    .ctlData    (ctlData),
    .ctlWrReq   (ctlWrReq),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .memDataOe  (memDataOe),
    .memWeN     (memWeN),
    .memOeN     (memOeN),
    .pixelOut   (pixelOut)
  );

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // reset state, R1
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset addr", 1, 32'(memAddr), 32'(scanAddr));
    check("R1 reset weN", 1, 32'(memWeN), 32'd1);
    check("R1 reset oeN", 1, 32'(memOeN), 32'd0);
    check("R1 reset doe", 1, 32'(memDataOe), 32'd0);
    check("R1 reset pixel", 1, 32'(pixelOut), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1 first cycle oeN", 1, 32'(memOeN), 32'd0);

    // R2: scanner address passes through in the same cycle
    @(negedge clk);
    scanAddr = 16'hBEEF;
    #1;
    check("R2 live scan addr", 2, 32'(memAddr), 32'hBEEF);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      ctlSelN     = VEC[i].sel;
      ctlWrReq    = VEC[i].wr;
      permitBlank = VEC[i].pb;
      visBlank    = VEC[i].vb;
      ctlAddr     = VEC[i].ca;
      ctlData     = VEC[i].cd;
      scanAddr    = VEC[i].sa;
      memRdData   = VEC[i].rd;
      @(posedge clk);
      #1;
      check($sformatf("vec %0d addr", i), int'(VEC[i].req), 32'(memAddr), 32'(VEC[i].exAddr));
      check($sformatf("vec %0d weN", i), int'(VEC[i].req), 32'(memWeN), 32'(VEC[i].exWeN));
      check($sformatf("vec %0d oeN", i), int'(VEC[i].req), 32'(memOeN), 32'(VEC[i].exOeN));
      check($sformatf("vec %0d doe", i), int'(VEC[i].req), 32'(memDataOe), 32'(VEC[i].exDoe));
      if (VEC[i].exDoe)
        check($sformatf("vec %0d wdata", i), int'(VEC[i].req), 32'(memWrData), 32'(VEC[i].exWd));
      check($sformatf("vec %0d pixel", i), int'(VEC[i].req), 32'(pixelOut), 32'(VEC[i].exPix));
    end

    // R1: reset in the middle of a strobe drops write enable at once
    @(negedge clk);
    visBlank = 1'b1; permitBlank = 1'b0; ctlSelN = 1'b0; scanAddr = 16'h0101;
    @(negedge clk);
    permitBlank = 1'b1; ctlAddr = 16'h2222;
    @(negedge clk);
    ctlWrReq = 1'b1;
    @(negedge clk);
    ctlWrReq = 1'b0;
    @(posedge clk);
    #1;
    check("R5 strobe reached", 5, 32'(memWeN), 32'd0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 async abort weN", 1, 32'(memWeN), 32'd1);
    check("R1 async abort addr", 1, 32'(memAddr), 32'h0101);
    @(negedge clk);
    rstN = 1'b1;
    // R3: window already open after reset -> no grant
    @(posedge clk);
    #1;
    check("R3 no grant after reset mid-window", 3, 32'(memOeN), 32'd0);

    finish_run();
  end

endmodule